// File: doc/BRIEF.md
# Translation Fault and Miss Capture Registers

This block sits behind a translation lookaside buffer and turns the outcome of each lookup into state that software can read. For every lookup it gets the hit flag, the protection attributes of the matching entry (privileged-only page, writable page) and the attributes of the access: user mode, write, virtual address and context number. When the access breaks a protection rule, the block updates a fault status register. On the data variant it also stores the faulting address. When the lookup misses, it loads a tag-access register with the page part of the address and the context in its low bits. For either event it raises a one-cycle exception strobe with a two-bit kind code.

A second fault can arrive before software has cleared the status from the first. In that case the status word is first replaced by an overflow code, and the bits of the new fault are then merged in. A software write clears the status register. A single parameter selects the data-side or instruction-side variant. The instruction side ignores write permission, never sets the write or fault-type status bits, and has no fault address register. A registered read port returns any of the capture registers one cycle after selection.

Top module: `mmu_fault_capture`

## Requirements
- R1: After reset, status, fault address and tag-access read as zero and `exc_valid` is low.
- R2: On a fault while status bit 0 is clear, status becomes the old value ORed with bit 0 (valid) and bit 3 (user access). On the data variant, bit 2 (write access) and bit 7 (privilege violation, the lowest bit of a fault-type field at bits 10:7) are ORed in as well.
- R3: On a fault while status bit 0 is already set, the status is first replaced by the overflow code 2 (bit 1), and the bits of R2 are then ORed in.
- R4: On a data-variant fault, the fault address register takes the access virtual address. A fault address register changes on no other event.
- R5: On a miss, tag-access becomes the virtual address with bits 12:0 cleared, ORed with the 13-bit context. Status and fault address do not change.
- R6: One cycle after a fault or a miss, `exc_valid` is high for one cycle with `exc_code` 0 = data fault, 1 = data miss, 2 = instruction fault, 3 = instruction miss.
- R7: A hit with no violation, or any cycle with `lkp_valid` low, changes no register and raises no strobe.
- R8: `sw_clr_stat` clears the status register. If a fault arrives in the same cycle, it is merged into the cleared value, so no overflow is recorded.
- R9: A data-variant fault is a privileged page accessed in user mode, or a write to a page that is not writable. The instruction variant checks only the privilege rule, and its fault address reads as zero.
- R10: `rd_data` shows, one cycle after `rd_sel` is applied, status (sel 0), fault address (sel 1), tag-access (sel 2) or zero (sel 3). The status value is zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lkp_valid | input | 1 | A lookup result is presented this cycle |
| lkp_hit | input | 1 | The lookup matched an entry |
| lkp_priv_page | input | 1 | Matching entry is for privileged access only |
| lkp_write_ok | input | 1 | Matching entry permits writes |
| acc_user | input | 1 | Access made in user mode |
| acc_write | input | 1 | Access is a write |
| acc_vaddr | input | VA_W | Access virtual address |
| acc_ctx | input | CTX_W | Access context number |
| sw_clr_stat | input | 1 | Software write clearing the status register |
| rd_sel | input | 2 | Register select for the read port |
| rd_data | output | VA_W | Registered read data |
| exc_valid | output | 1 | One-cycle exception strobe |
| exc_code | output | 2 | Exception kind |

## Verification
The hardest state to reach is an overflow followed by further faults, because the status word then holds a mix of the overflow code and merged bits. The stimulus reaches it by chaining two and three protection faults with no clear between them, then issuing a clear in the same cycle as a fault. One data-variant and one instruction-variant instance get identical stimulus. A write to a read-only page is therefore a fault on one instance and a clean hit on the other, and the scoreboard holds separate expected strobes and read values for each.

// File: rtl/mmu_cap_pkg.sv
package mmu_cap_pkg;
  typedef enum logic [1:0] {
    EXC_DFAULT = 2'd0,
    EXC_DMISS  = 2'd1,
    EXC_IFAULT = 2'd2,
    EXC_IMISS  = 2'd3
  } exc_kind_e;

  localparam logic [1:0] SEL_STAT = 2'd0;
  localparam logic [1:0] SEL_FAR  = 2'd1;
  localparam logic [1:0] SEL_TAG  = 2'd2;

  localparam int OVF_CODE = 2;
  localparam int USER_BIT = 3;
  localparam int WR_BIT   = 2;
endpackage

// File: rtl/mmu_cap_classify.sv
module mmu_cap_classify
  import mmu_cap_pkg::*;
#(
  parameter int IS_DATA = 1
) (
  input  logic      lkp_valid,
  input  logic      lkp_hit,
  input  logic      priv_page,
  input  logic      write_ok,
  input  logic      user,
  input  logic      write,
  output logic      fault_evt,
  output logic      miss_evt,
  output logic      priv_viol,
  output exc_kind_e kind
);
  logic hit_ok;
  logic wr_viol;

  assign hit_ok    = lkp_valid & lkp_hit;
  assign priv_viol = hit_ok & priv_page & user;
  assign miss_evt  = lkp_valid & ~lkp_hit;

  generate
    if (IS_DATA != 0) begin : g_data
      assign wr_viol = hit_ok & write & ~write_ok;
      assign kind    = (priv_viol | wr_viol) ? EXC_DFAULT : EXC_DMISS;
    end else begin : g_inst
      assign wr_viol = 1'b0;
      assign kind    = priv_viol ? EXC_IFAULT : EXC_IMISS;
    end
  endgenerate

  assign fault_evt = priv_viol | wr_viol;
endmodule

// File: rtl/mmu_cap_status.sv
module mmu_cap_status
  import mmu_cap_pkg::*;
#(
  parameter int IS_DATA = 1,
  parameter int STAT_W  = 16,
  parameter int FT_LSB  = 7,
  parameter int FT_W    = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fault_evt,
  input  logic              priv_viol,
  input  logic              user,
  input  logic              write,
  input  logic              sw_clr,
  output logic [STAT_W-1:0] stat_q
);
  logic [STAT_W-1:0] base;
  logic [STAT_W-1:0] nxt;
  logic [FT_W-1:0]   ftype;

  assign ftype = FT_W'(priv_viol);

  always_comb begin
    base = sw_clr ? '0 : stat_q;
    nxt  = base;
    if (fault_evt) begin
      if (base[0]) base = STAT_W'(OVF_CODE);
      nxt = base | STAT_W'(1) | (STAT_W'(user) << USER_BIT);
      if (IS_DATA != 0)
        nxt = nxt | (STAT_W'(write) << WR_BIT) | (STAT_W'(ftype) << FT_LSB);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) stat_q <= '0;
    else     stat_q <= nxt;
  end
endmodule

// File: rtl/mmu_cap_addr.sv
module mmu_cap_addr #(
  parameter int IS_DATA = 1,
  parameter int VA_W    = 64,
  parameter int CTX_W   = 13
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fault_evt,
  input  logic             miss_evt,
  input  logic [VA_W-1:0]  vaddr,
  input  logic [CTX_W-1:0] ctx,
  output logic [VA_W-1:0]  far_q,
  output logic [VA_W-1:0]  tag_q
);
  localparam int PG_W = VA_W - CTX_W;

  always_ff @(posedge clk) begin
    if (rst)           tag_q <= '0;
    else if (miss_evt) tag_q <= {vaddr[VA_W-1 -: PG_W], ctx};
  end

  generate
    if (IS_DATA != 0) begin : g_far
      always_ff @(posedge clk) begin
        if (rst)            far_q <= '0;
        else if (fault_evt) far_q <= vaddr;
      end
    end else begin : g_nofar
      assign far_q = '0;
    end
  endgenerate
endmodule

// File: rtl/mmu_cap_rdport.sv
module mmu_cap_rdport
  import mmu_cap_pkg::*;
#(
  parameter int VA_W   = 64,
  parameter int STAT_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        sel,
  input  logic [STAT_W-1:0] stat_q,
  input  logic [VA_W-1:0]   far_q,
  input  logic [VA_W-1:0]   tag_q,
  output logic [VA_W-1:0]   rd_data
);
  logic [VA_W-1:0] mux;

  always_comb begin
    case (sel)
      SEL_STAT: mux = VA_W'(stat_q);
      SEL_FAR:  mux = far_q;
      SEL_TAG:  mux = tag_q;
      default:  mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= mux;
  end
endmodule

// File: rtl/mmu_fault_capture.sv
module mmu_fault_capture
  import mmu_cap_pkg::*;
#(
  parameter int IS_DATA = 1,
  parameter int VA_W    = 64,
  parameter int CTX_W   = 13,
  parameter int STAT_W  = 16,
  parameter int FT_LSB  = 7,
  parameter int FT_W    = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             lkp_valid,
  input  logic             lkp_hit,
  input  logic             lkp_priv_page,
  input  logic             lkp_write_ok,
  input  logic             acc_user,
  input  logic             acc_write,
  input  logic [VA_W-1:0]  acc_vaddr,
  input  logic [CTX_W-1:0] acc_ctx,
  input  logic             sw_clr_stat,
  input  logic [1:0]       rd_sel,
  output logic [VA_W-1:0]  rd_data,
  output logic             exc_valid,
  output logic [1:0]       exc_code
);
  logic              fault_evt;
  logic              miss_evt;
  logic              priv_viol;
  exc_kind_e         kind;
  logic [STAT_W-1:0] stat_q;
  logic [VA_W-1:0]   far_q;
  logic [VA_W-1:0]   tag_q;

  mmu_cap_classify #(.IS_DATA(IS_DATA)) u_cls (
    .lkp_valid(lkp_valid), .lkp_hit(lkp_hit), .priv_page(lkp_priv_page),
    .write_ok(lkp_write_ok), .user(acc_user), .write(acc_write),
    .fault_evt(fault_evt), .miss_evt(miss_evt), .priv_viol(priv_viol), .kind(kind)
  );

  mmu_cap_status #(.IS_DATA(IS_DATA), .STAT_W(STAT_W), .FT_LSB(FT_LSB), .FT_W(FT_W)) u_stat (
    .clk(clk), .rst(rst), .fault_evt(fault_evt), .priv_viol(priv_viol),
    .user(acc_user), .write(acc_write), .sw_clr(sw_clr_stat), .stat_q(stat_q)
  );

  mmu_cap_addr #(.IS_DATA(IS_DATA), .VA_W(VA_W), .CTX_W(CTX_W)) u_addr (
    .clk(clk), .rst(rst), .fault_evt(fault_evt), .miss_evt(miss_evt),
    .vaddr(acc_vaddr), .ctx(acc_ctx), .far_q(far_q), .tag_q(tag_q)
  );

  mmu_cap_rdport #(.VA_W(VA_W), .STAT_W(STAT_W)) u_rd (
    .clk(clk), .rst(rst), .sel(rd_sel), .stat_q(stat_q),
    .far_q(far_q), .tag_q(tag_q), .rd_data(rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      exc_valid <= 1'b0;
      exc_code  <= 2'd0;
    end else begin
      exc_valid <= fault_evt | miss_evt;
      exc_code  <= kind;
    end
  end
endmodule

// File: rtl/mmu_fault_capture_chk.sv
module mmu_fault_capture_chk #(
  parameter int IS_DATA = 1,
  parameter int VA_W    = 64,
  parameter int CTX_W   = 13,
  parameter int STAT_W  = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              lkp_valid,
  input logic              lkp_hit,
  input logic              lkp_priv_page,
  input logic              lkp_write_ok,
  input logic              sw_clr_stat,
  input logic [VA_W-1:0]   acc_vaddr,
  input logic [CTX_W-1:0]  acc_ctx,
  input logic              exc_valid,
  input logic [1:0]        exc_code,
  input logic              fault_evt,
  input logic [STAT_W-1:0] stat_q,
  input logic [VA_W-1:0]   far_q,
  input logic [VA_W-1:0]   tag_q
);
  logic armed = 1'b0;
  always_ff @(posedge clk) armed <= !rst;

  a_r6_strobe_needs_lookup: assert property (@(posedge clk) disable iff (rst || !armed)
    exc_valid |-> $past(lkp_valid));

  a_r6_code_side: assert property (@(posedge clk) disable iff (rst)
    exc_valid |-> ((IS_DATA != 0) ? !exc_code[1] : exc_code[1]));

  a_r2_valid_bit: assert property (@(posedge clk) disable iff (rst || !armed)
    $past(fault_evt) |-> stat_q[0]);

  a_r3_overflow: assert property (@(posedge clk) disable iff (rst || !armed)
    $past(fault_evt && stat_q[0] && !sw_clr_stat) |-> (stat_q[1] && stat_q[0]));

  a_r4_far_capture: assert property (@(posedge clk) disable iff (rst || !armed)
    ((IS_DATA != 0) && $past(fault_evt)) |-> far_q == $past(acc_vaddr));

  a_r5_miss_tag_ctx: assert property (@(posedge clk) disable iff (rst || !armed)
    $past(lkp_valid && !lkp_hit) |-> tag_q[CTX_W-1:0] == $past(acc_ctx));

  a_r5_miss_keeps_status: assert property (@(posedge clk) disable iff (rst || !armed)
    $past(lkp_valid && !lkp_hit && !sw_clr_stat) |-> $stable(stat_q));

  a_r7_clean_hit_quiet: assert property (@(posedge clk) disable iff (rst || !armed)
    $past(lkp_valid && lkp_hit && !lkp_priv_page && lkp_write_ok && !sw_clr_stat)
      |-> (!exc_valid && $stable(stat_q) && $stable(tag_q)));

  a_r8_clear: assert property (@(posedge clk) disable iff (rst || !armed)
    $past(sw_clr_stat && !fault_evt) |-> stat_q == '0);
endmodule

bind mmu_fault_capture mmu_fault_capture_chk #(
  .IS_DATA(IS_DATA), .VA_W(VA_W), .CTX_W(CTX_W), .STAT_W(STAT_W)
) u_chk (
  .clk(clk), .rst(rst), .lkp_valid(lkp_valid), .lkp_hit(lkp_hit),
  .lkp_priv_page(lkp_priv_page), .lkp_write_ok(lkp_write_ok),
  .sw_clr_stat(sw_clr_stat), .acc_vaddr(acc_vaddr), .acc_ctx(acc_ctx),
  .exc_valid(exc_valid), .exc_code(exc_code), .fault_evt(fault_evt),
  .stat_q(stat_q), .far_q(far_q), .tag_q(tag_q)
);

// File: tb/mmu_fault_capture_bench.sv
module mmu_fault_capture_bench;
  localparam int CLK_PERIOD = 10;
  localparam int VA_W  = 64;
  localparam int CTX_W = 13;
  localparam int WATCHDOG = 5000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic lkp_valid = 0, lkp_hit = 0, lkp_priv_page = 0, lkp_write_ok = 1;
  logic acc_user = 0, acc_write = 0, sw_clr_stat = 0;
  logic [VA_W-1:0]  acc_vaddr = '0;
  logic [CTX_W-1:0] acc_ctx = '0;
  logic [1:0] rd_sel = 2'd3;
  logic rd_issue = 1'b0, rd_issue_q = 1'b0;

  logic [VA_W-1:0] rd_d, rd_i;
  logic exc_v_d, exc_v_i;
  logic [1:0] exc_c_d, exc_c_i;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // model state, [0] data side, [1] instruction side
  logic [15:0]     m_stat [2];
  logic [VA_W-1:0] m_far, m_tag [2];

  logic [1:0]      exq_d[$], exq_i[$];
  string           exq_rd[$], exq_ri[$];
  logic [VA_W-1:0] rdq_d[$], rdq_i[$];
  string           rdq_r[$];

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) rd_issue_q <= rd_issue;

  mmu_fault_capture #(.IS_DATA(1)) u_mmu_fault_capture (
    .clk(clk), .rst(rst), .lkp_valid(lkp_valid), .lkp_hit(lkp_hit),
    .lkp_priv_page(lkp_priv_page), .lkp_write_ok(lkp_write_ok),
    .acc_user(acc_user), .acc_write(acc_write), .acc_vaddr(acc_vaddr),
    .acc_ctx(acc_ctx), .sw_clr_stat(sw_clr_stat), .rd_sel(rd_sel),
    .rd_data(rd_d), .exc_valid(exc_v_d), .exc_code(exc_c_d));

  mmu_fault_capture #(.IS_DATA(0)) u_mmu_fault_capture_inst (
    .clk(clk), .rst(rst), .lkp_valid(lkp_valid), .lkp_hit(lkp_hit),
    .lkp_priv_page(lkp_priv_page), .lkp_write_ok(lkp_write_ok),
    .acc_user(acc_user), .acc_write(acc_write), .acc_vaddr(acc_vaddr),
    .acc_ctx(acc_ctx), .sw_clr_stat(sw_clr_stat), .rd_sel(rd_sel),
    .rd_data(rd_i), .exc_valid(exc_v_i), .exc_code(exc_c_i));

  task automatic check(input bit ok, input string req, input string what,
                       input logic [VA_W-1:0] act, input logic [VA_W-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // model of one side, applied to both from the requirements
  task automatic model(input int side, input bit hit, input bit priv, input bit wok,
                       input bit usr, input bit wr, input logic [VA_W-1:0] va,
                       input logic [CTX_W-1:0] ctx, input bit clr, input string req);
    bit flt;
    logic [15:0] b;
    flt = hit && ((priv && usr) || (side == 0 && wr && !wok));   // R9
    b = clr ? 16'h0 : m_stat[side];                              // R8
    if (flt) begin
      if (b[0]) b = 16'h0002;                                    // R3
      b = b | 16'h0001 | (16'(usr) << 3);                        // R2
      if (side == 0) b = b | (16'(wr) << 2) | (16'(priv && usr) << 7);
      if (side == 0) m_far = va;                                 // R4
    end
    m_stat[side] = b;
    if (!hit) m_tag[side] = (va & ~64'h1fff) | VA_W'(ctx);       // R5
    if (flt || !hit) begin                                       // R6
      if (side == 0) begin exq_d.push_back(flt ? 2'd0 : 2'd1); exq_rd.push_back(req); end
      else           begin exq_i.push_back(flt ? 2'd2 : 2'd3); exq_ri.push_back(req); end
    end
  endtask

  task automatic look(input bit hit, input bit priv, input bit wok, input bit usr,
                      input bit wr, input logic [VA_W-1:0] va, input logic [CTX_W-1:0] ctx,
                      input bit clr, input string req);
    @(negedge clk);
    lkp_valid = 1; lkp_hit = hit; lkp_priv_page = priv; lkp_write_ok = wok;
    acc_user = usr; acc_write = wr; acc_vaddr = va; acc_ctx = ctx; sw_clr_stat = clr;
    model(0, hit, priv, wok, usr, wr, va, ctx, clr, req);
    model(1, hit, priv, wok, usr, wr, va, ctx, clr, req);
  endtask

  task automatic idle();
    @(negedge clk);
    lkp_valid = 0; lkp_hit = 0; sw_clr_stat = 0;
  endtask

  task automatic rd(input logic [1:0] sel, input string req);
    @(negedge clk);
    rd_sel = sel; rd_issue = 1;
    case (sel)
      2'd0: begin rdq_d.push_back(VA_W'(m_stat[0])); rdq_i.push_back(VA_W'(m_stat[1])); end
      2'd1: begin rdq_d.push_back(m_far); rdq_i.push_back('0); end
      2'd2: begin rdq_d.push_back(m_tag[0]); rdq_i.push_back(m_tag[1]); end
      default: begin rdq_d.push_back('0); rdq_i.push_back('0); end
    endcase
    rdq_r.push_back(req);
    @(negedge clk);
    rd_issue = 0;
  endtask

  // monitor: pops the scoreboard as results appear
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && !done) begin
        if (exc_v_d) begin
          if (exq_d.size() == 0) check(0, "R7", "unexpected data strobe", VA_W'(exc_c_d), '0);
          else begin
            logic [1:0] e; string r;
            e = exq_d.pop_front(); r = exq_rd.pop_front();
            check(exc_c_d == e, r, "data exc_code", VA_W'(exc_c_d), VA_W'(e));
          end
        end
        if (exc_v_i) begin
          if (exq_i.size() == 0) check(0, "R7", "unexpected inst strobe", VA_W'(exc_c_i), '0);
          else begin
            logic [1:0] e; string r;
            e = exq_i.pop_front(); r = exq_ri.pop_front();
            check(exc_c_i == e, r, "inst exc_code", VA_W'(exc_c_i), VA_W'(e));
          end
        end
        if (rd_issue_q && rdq_r.size() != 0) begin
          logic [VA_W-1:0] ed, ei; string r;
          ed = rdq_d.pop_front(); ei = rdq_i.pop_front(); r = rdq_r.pop_front();
          check(rd_d == ed, r, "data rd_data", rd_d, ed);
          check(rd_i == ei, r, "inst rd_data", rd_i, ei);
        end
      end
    end
  end

  task automatic finish_run();
    done = 1;
    check(exq_d.size() == 0 && exq_i.size() == 0, "R6", "missing strobes",
          VA_W'(exq_d.size() + exq_i.size()), '0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    check(0, "R1", "watchdog expired", '0, '0);
    finish_run();
  end

  initial begin
    logic [VA_W-1:0] va1, va2, va3;
    va1 = 64'h1234_5678_9ABC_DEF0;
    va2 = 64'hFFFF_0000_0000_3FFF;
    va3 = 64'h0000_7FFF_ABCD_E123;
    m_stat[0] = '0; m_stat[1] = '0; m_far = '0; m_tag[0] = '0; m_tag[1] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    // R1 reset values, R10 all selects
    @(negedge clk);
    check(!exc_v_d && !exc_v_i, "R1", "strobe after reset", VA_W'(exc_v_d), '0);
    rd(2'd0, "R1"); rd(2'd1, "R1"); rd(2'd2, "R1"); rd(2'd3, "R10");
    // R7 clean hit, and a cycle with lkp_valid low
    look(1, 0, 1, 1, 1, va1, 13'h0AA, 0, "R7"); idle();
    rd(2'd0, "R7"); rd(2'd2, "R7");
    // R5 miss
    look(0, 0, 1, 0, 0, va1, 13'h155, 0, "R5"); idle();
    rd(2'd2, "R5"); rd(2'd0, "R5"); rd(2'd1, "R5");
    // R9 write to read-only page: data fault, inst clean
    look(1, 0, 0, 0, 1, va2, 13'h001, 0, "R9"); idle();
    rd(2'd0, "R9"); rd(2'd1, "R4");
    // R3 privilege fault on top of existing fault (data) / first fault (inst)
    look(1, 1, 1, 1, 0, va3, 13'h002, 0, "R3"); idle();
    rd(2'd0, "R3"); rd(2'd1, "R4");
    // R2 and R3 chained again with write
    look(1, 1, 1, 1, 1, va1, 13'h003, 0, "R2"); idle();
    rd(2'd0, "R2"); rd(2'd3, "R10");
    // R8 clear alone
    @(negedge clk); sw_clr_stat = 1;
    m_stat[0] = '0; m_stat[1] = '0;
    idle(); rd(2'd0, "R8");
    // R8 clear together with a fault, after making status valid again
    look(1, 1, 1, 1, 0, va2, 13'h004, 0, "R2"); idle();
    look(1, 1, 1, 1, 0, va3, 13'h005, 1, "R8"); idle();
    rd(2'd0, "R8"); rd(2'd1, "R4");
    // R6 back-to-back misses, R5 last tag kept
    look(0, 0, 1, 0, 0, va2, 13'h1FFF, 0, "R6");
    look(0, 0, 1, 1, 1, va3, 13'h0777, 0, "R6"); idle();
    rd(2'd2, "R5"); rd(2'd0, "R5");
    // R7 lkp_valid low with miss-looking inputs
    @(negedge clk); lkp_valid = 0; lkp_hit = 0; acc_vaddr = va1; acc_ctx = 13'h0123;
    idle(); rd(2'd2, "R7");
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule